// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a 32-bit synchronous SRAM with a one-stage read pipeline. Every control input and the address are captured on the rising clock edge. The captured inputs are chip enable, address strobe, write enable and four byte-lane write enables. The output enable works without the clock. The shared data bus is split into an input word, an output word and an output-drive flag. Outside the block, those three ports are joined into a tri-state bus.

A cycle with the address strobe low and chip enable low starts a burst at the external address. That address is then held inside the block. A cycle with the address strobe high is a wait cycle. It accesses the held address again and leaves it unchanged, whatever the level of chip enable. The burst position is the low two bits of the held address.

Read data is registered. It appears one clock after the read cycle is captured, and it drives the bus only while output enable is low. Writes are masked per byte lane.

Top module: `burst_sram`

## Requirements
- R1: A cycle with chip enable high (`ce_n`=1) and address strobe low (`strobe_n`=0) is a deselect. After that clock edge, `d_oe` is 0.
- R2: With `ce_n`=0 and `strobe_n`=0, a cycle starts a burst at `addr`. If `we_n`=0, the cycle writes `d_in` to that address.
- R3: With `ce_n`=0, `strobe_n`=0 and `we_n`=1, the cycle is a read. The stored word appears on `d_out` with `d_oe`=1 after the next rising edge, provided `oe_n`=0.
- R4: Whenever `oe_n` is 1, `d_oe` is 0, even while read data is pending. Output enable acts without waiting for a clock edge.
- R5: A cycle with `strobe_n`=1 reads the held burst address again if `we_n`=1, for either level of `ce_n`. The held address does not change.
- R6: A cycle with `strobe_n`=1 and `we_n`=0 writes `d_in` to the held burst address.
- R7: The byte-lane enables are active low. `lane_we_n[0]` gates bits 7:0, `[1]` gates bits 15:8, `[2]` gates bits 23:16 and `[3]` gates bits 31:24. A lane whose enable is 1 keeps its old byte on a write.
- R8: On a read, the lane enables are ignored. The full stored word is returned, and the memory is unchanged.
- R9: While reset (`rst_n`=0) is sampled low, `d_oe` is 0 after the edge.
- R10: Any write cycle sets `d_oe` to 0 after its edge.
- R11: A deselect cycle neither writes the memory nor changes the held burst address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` are captured on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| strobe_n | input | 1 | Address strobe, active low; low starts a burst or deselects |
| we_n | input | 1 | Write enable, active low |
| lane_we_n | input | 4 | Byte-lane write enables, active low |
| addr | input | ADDR_W (6) | External word address |
| oe_n | input | 1 | Output enable, active low, not clocked |
| d_in | input | 32 | Write data from the bus |
| d_out | output | 32 | Registered read data |
| d_oe | output | 1 | High when the block drives the bus |

## Verification
The directed cases write a full word and then overwrite single lanes. Each lane's bit field is checked separately, so a lane mapped to the wrong bits or a lane ignored on a write becomes visible. Wait cycles are checked with chip enable both high and low, and one wait cycle comes after a deselect that carried a different address. These cases separate reusing the held address from capturing the new external address. Output-enable toggles during a pending read, writes that follow reads, and a reset in mid-read check that every route to high impedance is independent of the others.

// File: rtl/burst_sram_pkg.sv
// Shared types for the pipelined burst SRAM.
// Assumes the cycle kinds are decoded once and used by every submodule.
package burst_sram_pkg;

    typedef enum logic [2:0] {
        CYC_DESEL    = 3'd0,
        CYC_START_RD = 3'd1,
        CYC_START_WR = 3'd2,
        CYC_WAIT_RD  = 3'd3,
        CYC_WAIT_WR  = 3'd4
    } cyc_kind_e;

    function automatic logic is_write(input cyc_kind_e k);
        return (k == CYC_START_WR) || (k == CYC_WAIT_WR);
    endfunction

    function automatic logic is_read(input cyc_kind_e k);
        return (k == CYC_START_RD) || (k == CYC_WAIT_RD);
    endfunction

endpackage

// File: rtl/burst_sram_decode.sv
// Classifies the captured control inputs into one cycle kind.
// Assumes the inputs are stable around the rising edge. Strobe high always
// means a wait cycle, whatever the level of chip enable.
module burst_sram_decode
    import burst_sram_pkg::*;
(
    input  logic      ce_n,
    input  logic      strobe_n,
    input  logic      we_n,
    output cyc_kind_e kind
);

    // Decode the control inputs into a cycle kind
    always_comb begin
        if (strobe_n) begin
            kind = we_n ? CYC_WAIT_RD : CYC_WAIT_WR;
        end else if (ce_n) begin
            kind = CYC_DESEL;
        end else begin
            kind = we_n ? CYC_START_RD : CYC_START_WR;
        end
    end

endmodule

// File: rtl/burst_sram_addr.sv
// Holds the burst address. A start cycle loads it from the external address;
// wait and deselect cycles leave it as it is. Assumes a synchronous
// active-low reset.
module burst_sram_addr
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_kind_e         kind,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam int POS_W = 2;

    logic [ADDR_W-1:0]     held_q;
    logic                  start_c;
    logic [POS_W-1:0]      burst_pos;

    assign start_c   = (kind == CYC_START_RD) || (kind == CYC_START_WR);
    assign burst_pos = start_c ? ext_addr[POS_W-1:0] : held_q[POS_W-1:0];

    // Pick the address used by this cycle: external on a start, held otherwise
    always_comb begin
        acc_addr = start_c ? ext_addr : held_q;
        acc_addr[POS_W-1:0] = burst_pos;
    end

    // Capture the burst start address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (start_c) begin
            held_q <= ext_addr;
        end
    end

    // R2: a start cycle loads the external address
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (held_q == $past(ext_addr)));

    // R5: a wait cycle keeps the held address
    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == CYC_WAIT_RD) || (kind == CYC_WAIT_WR)) |=> $stable(held_q));

    // R11: a deselect keeps the held address
    p_desel_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_DESEL) |=> $stable(held_q));

endmodule

// File: rtl/burst_sram_array.sv
// Word storage split into byte lanes, each with its own active-low write
// enable. The read port is combinational; the output stage registers it.
// Assumes the memory contents need no reset.
module burst_sram_array #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [DATA_W/8-1:0] lane_we_n,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   rd_word
);

    localparam int LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [DEPTH];

        // Write this lane when the cycle writes and its enable is low
        always_ff @(posedge clk) begin
            if (wr_en && !lane_we_n[g]) begin
                mem[acc_addr] <= din[8*g +: 8];
            end
        end

        assign rd_word[8*g +: 8] = mem[acc_addr];
    end

endmodule

// File: rtl/burst_sram_outstage.sv
// Read pipeline register and bus drive control. Read data is registered one
// clock after the read cycle; the drive flag is gated by output enable
// without waiting for the clock. Assumes a synchronous active-low reset.
module burst_sram_outstage
    import burst_sram_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_kind_e         kind,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              oe_n,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe
);

    logic [DATA_W-1:0] data_q;
    logic              vld_q;

    // Register the read word and mark whether it may be driven
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            data_q <= '0;
        end else begin
            vld_q <= is_read(kind);
            if (is_read(kind)) begin
                data_q <= rd_word;
            end
        end
    end

    assign d_out = data_q;
    assign d_oe  = vld_q & ~oe_n;

    // R1: a deselect leaves the bus undriven
    p_desel_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_DESEL) |=> !d_oe);

    // R3: a read cycle makes data pending for the next cycle
    p_read_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_read(kind) |=> vld_q);

    // R10: a write cycle leaves the bus undriven
    p_write_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_write(kind) |=> !d_oe);

    // R9: reset forces high impedance
    p_reset_hiz_r9: assert property (@(posedge clk)
        !rst_n |=> !vld_q);

endmodule

// File: rtl/burst_sram.sv
// Top of the pipelined burst SRAM. Wires the cycle decoder, burst address
// holder, byte-lane array and output stage. Assumes the external bus joins
// d_in, d_out and d_oe into a tri-state bus.
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                strobe_n,
    input  logic                we_n,
    input  logic [DATA_W/8-1:0] lane_we_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                oe_n,
    input  logic [DATA_W-1:0]   d_in,
    output logic [DATA_W-1:0]   d_out,
    output logic                d_oe
);

    cyc_kind_e         kind;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] rd_word;
    logic              wr_en;

    assign wr_en = is_write(kind);

    burst_sram_decode u_decode (
        .ce_n     (ce_n),
        .strobe_n (strobe_n),
        .we_n     (we_n),
        .kind     (kind)
    );

    burst_sram_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .ext_addr (addr),
        .acc_addr (acc_addr)
    );

    burst_sram_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .wr_en     (wr_en),
        .lane_we_n (lane_we_n),
        .acc_addr  (acc_addr),
        .din       (d_in),
        .rd_word   (rd_word)
    );

    burst_sram_outstage #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .rd_word (rd_word),
        .oe_n    (oe_n),
        .d_out   (d_out),
        .d_oe    (d_oe)
    );

endmodule

// File: tb/burst_sram_tb_top.sv
// Directed bench for the pipelined burst SRAM, one task per scenario.
module burst_sram_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        strobe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [3:0]  lane_we_n = 4'hF;
    logic [5:0]  addr = '0;
    logic        oe_n = 1'b0;
    logic [31:0] d_in = '0;
    logic [31:0] d_out;
    logic        d_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    burst_sram dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .strobe_n(strobe_n),
        .we_n(we_n), .lane_we_n(lane_we_n), .addr(addr), .oe_n(oe_n),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: drive after a falling edge, return after the next falling edge
    task automatic cyc(input logic ce, input logic st, input logic we,
                       input logic [3:0] ln, input logic [5:0] a, input logic [31:0] d);
        ce_n = ce; strobe_n = st; we_n = we; lane_we_n = ln; addr = a; d_in = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_word(input logic [5:0] a, input logic [31:0] d, input logic [3:0] ln);
        cyc(1'b0, 1'b0, 1'b0, ln, a, d);
    endtask

    task automatic rd_word(input logic [5:0] a);
        cyc(1'b0, 1'b0, 1'b1, 4'hF, a, 32'h0);
    endtask

    task automatic t_reset;
        oe_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 reset hiz", {31'b0, d_oe}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_write_read;
        wr_word(6'd5, 32'h1122_3344, 4'h0);
        chk("R10 write hiz", {31'b0, d_oe}, 32'h0);
        rd_word(6'd5);
        chk("R3 read drive", {31'b0, d_oe}, 32'h1);
        chk("R2 R3 read data", d_out, 32'h1122_3344);
    endtask

    task automatic t_oe;
        rd_word(6'd5);
        oe_n = 1'b1;
        #1;
        chk("R4 oe high hiz", {31'b0, d_oe}, 32'h0);
        oe_n = 1'b0;
        #1;
        chk("R4 oe low drive", {31'b0, d_oe}, 32'h1);
    endtask

    task automatic t_lanes;
        wr_word(6'd9, 32'hFFFF_FFFF, 4'h0);
        wr_word(6'd9, 32'hAABB_CCDD, 4'b1110);
        rd_word(6'd9);
        chk("R7 lane0 only", d_out, 32'hFFFF_FFDD);
        wr_word(6'd9, 32'hAABB_CCDD, 4'b1011);
        rd_word(6'd9);
        chk("R7 lane2 only", d_out, 32'hFFBB_FFDD);
        wr_word(6'd9, 32'h1234_5678, 4'b0101);
        rd_word(6'd9);
        chk("R7 lanes 1 3", d_out, 32'h12BB_56DD);
    endtask

    task automatic t_read_ignores_lanes;
        cyc(1'b0, 1'b0, 1'b1, 4'h0, 6'd9, 32'h0);
        chk("R8 read with lanes low", d_out, 32'h12BB_56DD);
        rd_word(6'd9);
        chk("R8 memory unchanged", d_out, 32'h12BB_56DD);
    endtask

    task automatic t_wait;
        wr_word(6'd14, 32'hCAFE_0014, 4'h0);
        wr_word(6'd13, 32'hCAFE_0013, 4'h0);
        rd_word(6'd13);
        cyc(1'b1, 1'b1, 1'b1, 4'hF, 6'd14, 32'h0);
        chk("R5 wait ce high", d_out, 32'hCAFE_0013);
        cyc(1'b0, 1'b1, 1'b1, 4'hF, 6'd14, 32'h0);
        chk("R5 wait ce low", d_out, 32'hCAFE_0013);
        cyc(1'b1, 1'b1, 1'b0, 4'h0, 6'd14, 32'h0000_0BEE);
        chk("R10 wait write hiz", {31'b0, d_oe}, 32'h0);
        rd_word(6'd13);
        chk("R6 wait write held", d_out, 32'h0000_0BEE);
        rd_word(6'd14);
        chk("R6 other word kept", d_out, 32'hCAFE_0014);
    endtask

    task automatic t_deselect;
        rd_word(6'd13);
        cyc(1'b1, 1'b0, 1'b0, 4'h0, 6'd5, 32'hDEAD_BEEF);
        chk("R1 deselect hiz", {31'b0, d_oe}, 32'h0);
        cyc(1'b1, 1'b1, 1'b1, 4'hF, 6'd5, 32'h0);
        chk("R11 held addr kept", d_out, 32'h0000_0BEE);
        rd_word(6'd5);
        chk("R11 no write", d_out, 32'h1122_3344);
    endtask

    task automatic t_reset_mid_read;
        rd_word(6'd5);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 reset during read", {31'b0, d_oe}, 32'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_write_read();
        t_oe();
        t_lanes();
        t_read_ignores_lanes();
        t_wait();
        t_deselect();
        t_reset_mid_read();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule